// File: doc/BRIEF.md
# Exception context stack sequencer

This block saves the return context when an exception is taken and restores it on return from the handler. On a push request it writes a fixed two-word frame to data memory through a word-wide port: first the low sixteen bits of the 24-bit return PC, then a word that carries the 8-bit status low byte in its upper half and PC bits 23:16 in its lower half. On a pop request it reads the same two words back in reverse order and presents the rebuilt PC and status byte.

The block owns a 16-bit stack pointer that stands in for working register 15. The stack grows upward. A push writes at the pointer and then adds 2. A pop first subtracts 2 and then reads at the new address. Bit 0 of the pointer is always zero. A separate guard watches instruction fetches and raises an address-error trap when a normal fetch falls in the vector area, program addresses 0x000000 to 0x00001F. A vector load made during exception entry does not raise it.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset `sp_o` equals parameter `SP_RESET` with bit 0 cleared (default 0x0100), and `busy_o`, `done_o`, `mem_we_o` and `mem_re_o` are all 0.
- R2: One cycle after an accepted push start, `mem_we_o` is 1, `mem_addr_o` equals the pointer value before the push, and `mem_wdata_o` equals PC[15:0].
- R3: In the next cycle `mem_we_o` is 1, `mem_addr_o` equals the earlier address plus 2, and `mem_wdata_o` equals {SR[7:0], PC[23:16]}.
- R4: A push adds 4 to `sp_o` and a pop subtracts 4. Each word transfer moves the pointer by exactly 2.
- R5: A pop reads at pointer minus 2 and then at pointer minus 4, each with `mem_re_o` = 1 and read data taken in the same cycle. The first word read gives SR in bits 15:8 and PC[23:16] in bits 7:0. The second word gives PC[15:0].
- R6: A start of either kind is ignored while `busy_o` is 1. Only the frame already in progress reaches memory.
- R7: When push and pop starts arrive together while the block is idle, the push is taken and the pop is dropped.
- R8: Bit 0 of `sp_o` is 0 at all times.
- R9: `addr_err_o` is 1 exactly when `fetch_valid_i` is 1, `vec_load_i` is 0 and `fetch_addr_i` is below 0x000020. It is combinational on those inputs.
- R10: `done_o` is a one-cycle pulse in the cycle after the second word. At that pulse `sp_o` shows the final value, and after a pop `pop_pc_o` and `pop_sr_o` show the restored context. Both restored values hold until the next pop.
- R11: While idle, no memory access is made (`mem_we_o` = `mem_re_o` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_start_i | input | 1 | Request to stack a context frame |
| push_pc_i | input | 24 | Return PC to stack |
| push_sr_i | input | 8 | Status low byte to stack |
| pop_start_i | input | 1 | Request to unstack a context frame |
| mem_addr_o | output | 16 | Data memory byte address |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_wdata_o | output | 16 | Data memory write word |
| mem_rdata_i | input | 16 | Data memory read word, valid in the cycle of `mem_re_o` |
| busy_o | output | 1 | Frame transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pop_pc_o | output | 24 | Restored PC |
| pop_sr_o | output | 8 | Restored status low byte |
| sp_o | output | 16 | Current stack pointer |
| fetch_valid_i | input | 1 | Instruction fetch in this cycle |
| fetch_addr_i | input | 24 | Instruction fetch program address |
| vec_load_i | input | 1 | Fetch is a vector load made during exception entry |
| addr_err_o | output | 1 | Address-error trap request |

## Verification
If a start is driven before clock edge E0, the first memory word appears in the cycle after E0 and the second word one cycle later. `done_o`, the final pointer value and the restored PC and status byte appear in the third cycle after E0. `addr_err_o` follows its inputs in the same cycle. The driver posts the expected memory transactions to a queue at start time. A monitor compares every cycle that has a strobe against the head of that queue, half a period after the edge. Completion checks are sampled at the third falling edge after the start, and the guard is sampled shortly after its inputs change.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PUSH0 = 3'd1,
    ST_PUSH1 = 3'd2,
    ST_POP0  = 3'd3,
    ST_POP1  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int unsigned SP_W     = 16,
  parameter logic [15:0] SP_RESET = 16'h0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] sp_dec_o
);
  localparam int unsigned WORD_W = SP_W - 1;
  localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(SP_RESET >> 1);

  // word index only; byte bit 0 is tied low
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= RST_WORD;
    else if (inc_i) word_q <= word_q + 1'b1;
    else if (dec_i) word_q <= word_q - 1'b1;
  end

  assign sp_o     = {word_q, 1'b0};
  assign sp_dec_o = {word_q - 1'b1, 1'b0};

  // R4
  sp_inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> sp_o == $past(sp_o) + SP_W'(2));
  // R4
  sp_dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i) |=> sp_o == $past(sp_o) - SP_W'(2));
endmodule

// File: rtl/ctx_vec_guard.sv
module ctx_vec_guard #(
  parameter int unsigned         PC_W      = 24,
  parameter logic [PC_W-1:0]     VEC_LIMIT = 24'h000020
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_addr_i,
  input  logic            vec_load_i,
  output logic            addr_err_o
);
  logic in_vec_area;
  assign in_vec_area = fetch_addr_i < VEC_LIMIT;
  assign addr_err_o  = fetch_valid_i & ~vec_load_i & in_vec_area;

  // R9
  vec_load_exempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_i |-> !addr_err_o);
  // R9
  no_fetch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !addr_err_o);
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int unsigned     SP_W      = 16,
  parameter int unsigned     DATA_W    = 16,
  parameter int unsigned     PC_W      = 24,
  parameter int unsigned     SR_W      = 8,
  parameter logic [15:0]     SP_RESET  = 16'h0100,
  parameter logic [PC_W-1:0] VEC_LIMIT = 24'h000020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_start_i,
  input  logic [PC_W-1:0]   push_pc_i,
  input  logic [SR_W-1:0]   push_sr_i,
  input  logic              pop_start_i,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PC_W-1:0]   pop_pc_o,
  output logic [SR_W-1:0]   pop_sr_o,
  output logic [SP_W-1:0]   sp_o,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_addr_i,
  input  logic              vec_load_i,
  output logic              addr_err_o
);
  localparam int unsigned PC_HI_W = PC_W - DATA_W;

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] push_lo_q, push_hi_q;
  logic [DATA_W-1:0] rest_lo_q, rest_hi_q;
  logic              done_q;
  logic              sp_inc, sp_dec;
  logic [SP_W-1:0]   sp_cur, sp_dec_addr;
  logic              idle, accept_push, accept_pop;

  assign idle        = state_q == ST_IDLE;
  assign accept_push = idle & push_start_i;
  assign accept_pop  = idle & pop_start_i & ~push_start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_push) state_d = ST_PUSH0;
                else if (accept_pop) state_d = ST_POP0;
      ST_PUSH0: state_d = ST_PUSH1;
      ST_PUSH1: state_d = ST_IDLE;
      ST_POP0:  state_d = ST_POP1;
      ST_POP1:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_PUSH1) | (state_q == ST_POP1);
    end
  end

  // frame is captured at start so caller inputs need not be held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_lo_q <= '0;
      push_hi_q <= '0;
    end else if (accept_push) begin
      push_lo_q <= push_pc_i[DATA_W-1:0];
      push_hi_q <= {push_sr_i, push_pc_i[PC_W-1 -: PC_HI_W]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rest_lo_q <= '0;
      rest_hi_q <= '0;
    end else begin
      if (state_q == ST_POP0) rest_hi_q <= mem_rdata_i;
      if (state_q == ST_POP1) rest_lo_q <= mem_rdata_i;
    end
  end

  assign sp_inc = (state_q == ST_PUSH0) | (state_q == ST_PUSH1);
  assign sp_dec = (state_q == ST_POP0)  | (state_q == ST_POP1);

  ctx_sp_reg #(
    .SP_W     (SP_W),
    .SP_RESET (SP_RESET)
  ) i_sp_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (sp_inc),
    .dec_i    (sp_dec),
    .sp_o     (sp_cur),
    .sp_dec_o (sp_dec_addr)
  );

  ctx_vec_guard #(
    .PC_W      (PC_W),
    .VEC_LIMIT (VEC_LIMIT)
  ) i_vec_guard (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .vec_load_i    (vec_load_i),
    .addr_err_o    (addr_err_o)
  );

  assign mem_we_o    = sp_inc;
  assign mem_re_o    = sp_dec;
  assign mem_addr_o  = sp_inc ? sp_cur : sp_dec_addr;
  assign mem_wdata_o = (state_q == ST_PUSH0) ? push_lo_q : push_hi_q;
  assign busy_o      = ~idle;
  assign done_o      = done_q;
  assign sp_o        = sp_cur;
  assign pop_pc_o    = {rest_hi_q[PC_HI_W-1:0], rest_lo_q};
  assign pop_sr_o    = rest_hi_q[DATA_W-1 -: SR_W];

  // R2
  push_first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && push_start_i) |=> mem_we_o && mem_addr_o == $past(sp_o));
  // R3
  push_second_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH0) |=> mem_we_o && mem_addr_o == $past(mem_addr_o) + SP_W'(2));
  // R5
  pop_second_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POP0) |=> mem_re_o && mem_addr_o == $past(mem_addr_o) - SP_W'(2));
  // R6
  busy_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH0) |=> state_q == ST_PUSH1);
  // R7
  push_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && push_start_i && pop_start_i) |=> mem_we_o && !mem_re_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o && !mem_re_o);
  // R8
  sp_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o[0] == 1'b0);
endmodule

// File: tb/test_ctx_stack_seq.sv
module test_ctx_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_start = 1'b0, pop_start = 1'b0;
  logic [23:0] push_pc = '0;
  logic [7:0]  push_sr = '0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re, busy, done;
  logic [23:0] pop_pc;
  logic [7:0]  pop_sr;
  logic [15:0] sp;
  logic        fetch_valid = 1'b0, vec_load = 1'b0;
  logic [23:0] fetch_addr = '0;
  logic        addr_err;

  int checks = 0, fails = 0;

  typedef struct packed { logic wr; logic [15:0] addr; logic [15:0] data; } xact_t;
  xact_t exp_q[$];
  logic [31:0] frames_q[$];   // {sr, pc}
  logic [15:0] sp_m;
  logic [15:0] mem_m [256];

  always #4 clk = ~clk;   // 125 MHz

  ctx_stack_seq i_ctx_stack_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .push_start_i(push_start), .push_pc_i(push_pc), .push_sr_i(push_sr),
    .pop_start_i(pop_start),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .pop_pc_o(pop_pc), .pop_sr_o(pop_sr),
    .sp_o(sp), .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .vec_load_i(vec_load), .addr_err_o(addr_err)
  );

  assign mem_rdata = mem_m[mem_addr[8:1]];
  always_ff @(posedge clk) if (mem_we) mem_m[mem_addr[8:1]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // monitor: compare every strobe cycle against the scoreboard head (R2 R3 R5 R11)
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected access", {15'd0, mem_we, mem_addr}, 32'd0);
      end else begin
        xact_t e;
        e = exp_q.pop_front();
        chk(mem_we == e.wr && mem_re == !e.wr, "R2/R5 access kind", {31'd0, mem_we}, {31'd0, e.wr});
        chk(mem_addr == e.addr, "R3/R5 address", {16'd0, mem_addr}, {16'd0, e.addr});
        if (e.wr) chk(mem_wdata == e.data, "R2/R3 write data", {16'd0, mem_wdata}, {16'd0, e.data});
      end
    end
  end

  task automatic finish_frame(input string req);
    repeat (2) @(negedge clk);
    chk(done == 1'b1, {req, " R10 done"}, {31'd0, done}, 32'd1);
    chk(sp == sp_m, {req, " R4 sp"}, {16'd0, sp}, {16'd0, sp_m});
    chk(sp[0] == 1'b0, "R8 align", {31'd0, sp[0]}, 32'd0);
  endtask

  // drive before edge E0; words at negedges 1,2; done at negedge 3
  task automatic do_push(input logic [23:0] pc, input logic [7:0] sr, input bit with_pop, input bit poke);
    @(negedge clk);
    push_start = 1'b1; push_pc = pc; push_sr = sr; pop_start = with_pop;
    exp_q.push_back('{1'b1, sp_m, pc[15:0]});
    exp_q.push_back('{1'b1, sp_m + 16'd2, {sr, pc[23:16]}});
    frames_q.push_back({sr, pc});
    sp_m = sp_m + 16'd4;
    @(negedge clk);
    if (poke) begin   // R6: restart requests while busy
      push_pc = ~pc; push_sr = ~sr; pop_start = 1'b1;
    end else begin
      push_start = 1'b0; pop_start = 1'b0;
    end
    @(negedge clk);
    push_start = 1'b0; pop_start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R10 push done", {31'd0, done}, 32'd1);
    chk(sp == sp_m, "R4 push sp", {16'd0, sp}, {16'd0, sp_m});
    chk(sp[0] == 1'b0, "R8 align", {31'd0, sp[0]}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", {31'd0, done}, 32'd0);
    chk(!busy, "R6 idle after frame", {31'd0, busy}, 32'd0);
  endtask

  task automatic do_pop();
    logic [31:0] f;
    f = frames_q.pop_back();
    @(negedge clk);
    pop_start = 1'b1;
    exp_q.push_back('{1'b0, sp_m - 16'd2, 16'd0});
    exp_q.push_back('{1'b0, sp_m - 16'd4, 16'd0});
    sp_m = sp_m - 16'd4;
    @(negedge clk);
    pop_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R10 pop done", {31'd0, done}, 32'd1);
    chk(sp == sp_m, "R4 pop sp", {16'd0, sp}, {16'd0, sp_m});
    chk(pop_pc == f[23:0], "R5 restored pc", {8'd0, pop_pc}, {8'd0, f[23:0]});
    chk(pop_sr == f[31:24], "R5 restored sr", {24'd0, pop_sr}, {24'd0, f[31:24]});
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", {31'd0, done}, 32'd0);
    chk(pop_pc == f[23:0], "R10 pc holds", {8'd0, pop_pc}, {8'd0, f[23:0]});
  endtask

  task automatic guard(input bit v, input logic [23:0] a, input bit vl, input bit exp);
    @(negedge clk);
    fetch_valid = v; fetch_addr = a; vec_load = vl;
    #1;
    chk(addr_err == exp, "R9 guard", {31'd0, addr_err}, {31'd0, exp});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    sp_m = 16'h0100;
    repeat (3) @(negedge clk);
    chk(sp == 16'h0100, "R1 reset sp", {16'd0, sp}, 32'h100);
    chk(!busy && !done, "R1 reset flags", {30'd0, busy, done}, 32'd0);
    chk(!mem_we && !mem_re, "R1 reset strobes", {30'd0, mem_we, mem_re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_we && !mem_re, "R11 idle quiet", {30'd0, mem_we, mem_re}, 32'd0);

    do_push(24'h12_3456, 8'hA5, 1'b0, 1'b0);
    do_push(24'hFE_DCBA, 8'h3C, 1'b0, 1'b1);   // R6
    do_push(24'h00_0001, 8'h00, 1'b1, 1'b0);   // R7
    do_pop();
    do_pop();
    do_push(24'hFF_FFFE, 8'hFF, 1'b0, 1'b0);
    do_pop();
    do_pop();
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 32'd0);
    chk(sp == 16'h0100, "R4 back to base", {16'd0, sp}, 32'h100);

    guard(1'b1, 24'h00_001F, 1'b0, 1'b1);
    guard(1'b1, 24'h00_0000, 1'b0, 1'b1);
    guard(1'b1, 24'h00_0020, 1'b0, 1'b0);
    guard(1'b1, 24'h00_0004, 1'b1, 1'b0);
    guard(1'b0, 24'h00_0010, 1'b0, 1'b0);
    guard(1'b1, 24'h80_0000, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule